// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Hazard Control

This block is the hazard controller of a five-stage in-order pipeline: fetch, decode with register read, execute, memory and writeback. Each instruction spends one clock in each stage. It looks at the source registers of the instructions in execute and in decode, and at the destinations of the instructions further down the pipeline. From these it chooses where each ALU operand in execute comes from. It also decides when the front of the pipeline must hold and when younger instructions must be cancelled.

A result from the instruction one stage ahead (in memory) or two stages ahead (in writeback) is bypassed to the execute operands. An instruction three behind its producer reads the register file, because the file writes in the first half of the cycle and reads in the second. When a load in execute feeds the instruction in decode, the block holds PC and the decode register for one cycle and sends a bubble into execute. The loaded value then comes from the writeback stage. Branches are predicted not taken. A taken branch, resolved in execute, cancels the two younger instructions already fetched.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An execute operand whose register matches the memory-stage destination, with that stage's write enable high and the register nonzero, gets select code 2'b10.
- R2: An operand that matches only the writeback destination, with write enable high and the register nonzero, gets select code 2'b01.
- R3: When both the memory and the writeback stages qualify for the same operand, the memory stage wins (2'b10). A memory match whose write enable is low does not block a writeback match.
- R4: Register 0 is never forwarded and never causes a stall. A destination whose write enable is low is never forwarded.
- R5: An operand with no qualifying match gets select code 2'b00 and reads the register file. Code 2'b11 is never produced.
- R6: A load in execute with a nonzero destination equal to either decode source raises stall_o and bubble_o in the same cycle.
- R7: No stall occurs when the execute instruction is not a load, or when its destination matches neither decode source.
- R8: stall_o is never high in two consecutive cycles. A load-use condition held over a second cycle gives no second stall.
- R9: A taken branch raises flush_o and bubble_o and forces stall_o low.
- R10: After reset, the first load-use condition stalls at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_rs1_i | input | 5 | First source register of the instruction in decode |
| id_rs2_i | input | 5 | Second source register of the instruction in decode |
| ex_rs1_i | input | 5 | First source register of the instruction in execute |
| ex_rs2_i | input | 5 | Second source register of the instruction in execute |
| ex_rd_i | input | 5 | Destination register of the instruction in execute |
| ex_is_load_i | input | 1 | The instruction in execute is a load |
| mem_rd_i | input | 5 | Destination register of the instruction in memory |
| mem_we_i | input | 1 | Register write enable of the instruction in memory |
| wb_rd_i | input | 5 | Destination register of the instruction in writeback |
| wb_we_i | input | 1 | Register write enable of the instruction in writeback |
| branch_taken_i | input | 1 | The branch in execute is taken |
| fwd_a_o | output | 2 | Select for ALU operand A: 00 register file, 01 writeback, 10 memory |
| fwd_b_o | output | 2 | Select for ALU operand B, same coding |
| stall_o | output | 1 | Hold PC and the decode register |
| bubble_o | output | 1 | Turn the ID/EX register into a bubble |
| flush_o | output | 1 | Turn the IF/ID register into a bubble |

## Verification
The assertions assume the inputs are stable around each rising edge. They also assume that a stall high in one cycle is not followed by a load-use condition that needs a second stall. In a real pipeline this holds, because the bubble moves the load out of execute. The bench changes inputs only at falling edges. It holds a load-use condition over two cycles on purpose, to show that the block alone suppresses the repeated stall. Forwarding selects are combinational and are checked within the same half cycle.

// File: rtl/hu_pkg.sv
package hu_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output hu_pkg::fwd_sel_e sel_o
);
  logic src_live, mem_hit, wb_hit;

  assign src_live = |src_i;
  assign mem_hit  = src_live && mem_we_i && (mem_rd_i == src_i);
  assign wb_hit   = src_live && wb_we_i && (wb_rd_i == src_i);

  // nearest producer first
  always_comb begin
    if (mem_hit)     sel_o = hu_pkg::FWD_MEM;
    else if (wb_hit) sel_o = hu_pkg::FWD_WB;
    else             sel_o = hu_pkg::FWD_RF;
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ex_is_load_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic             branch_taken_i,
  output logic             stall_o
);
  logic hazard, stall_q;

  assign hazard = ex_is_load_i && (|ex_rd_i) &&
                  ((ex_rd_i == id_rs1_i) || (ex_rd_i == id_rs2_i));
  // one bubble is enough; a taken branch kills the dependent anyway
  assign stall_o = hazard && !branch_taken_i && !stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= stall_o;
  end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic [REG_W-1:0] ex_rs1_i,
  input  logic [REG_W-1:0] ex_rs2_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_is_load_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  input  logic             branch_taken_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             stall_o,
  output logic             bubble_o,
  output logic             flush_o
);
  localparam int NUM_OPS = 2;

  logic [REG_W-1:0] op_src [NUM_OPS];
  hu_pkg::fwd_sel_e op_sel [NUM_OPS];
  logic             lu_stall;

  assign op_src[0] = ex_rs1_i;
  assign op_src[1] = ex_rs2_i;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_select #(.REG_W(REG_W)) u_sel (
      .src_i    (op_src[g]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (op_sel[g])
    );
  end

  load_use_detect #(.REG_W(REG_W)) u_lu (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ex_is_load_i   (ex_is_load_i),
    .ex_rd_i        (ex_rd_i),
    .id_rs1_i       (id_rs1_i),
    .id_rs2_i       (id_rs2_i),
    .branch_taken_i (branch_taken_i),
    .stall_o        (lu_stall)
  );

  assign fwd_a_o  = op_sel[0];
  assign fwd_b_o  = op_sel[1];
  assign stall_o  = lu_stall;
  assign bubble_o = lu_stall || branch_taken_i;
  assign flush_o  = branch_taken_i;
endmodule

// File: rtl/fwd_hazard_checker.sv
module fwd_hazard_checker #(
  parameter int REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] id_rs1_i,
  input logic [REG_W-1:0] id_rs2_i,
  input logic [REG_W-1:0] ex_rs1_i,
  input logic [REG_W-1:0] ex_rs2_i,
  input logic [REG_W-1:0] ex_rd_i,
  input logic             ex_is_load_i,
  input logic [REG_W-1:0] mem_rd_i,
  input logic             mem_we_i,
  input logic [REG_W-1:0] wb_rd_i,
  input logic             wb_we_i,
  input logic             branch_taken_i,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o,
  input logic             stall_o,
  input logic             bubble_o,
  input logic             flush_o
);
  assert_mem_hit_a_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && (|ex_rs1_i) && mem_rd_i == ex_rs1_i) |-> fwd_a_o == 2'b10);

  assert_mem_src_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_b_o == 2'b10) |-> (mem_we_i && mem_rd_i == ex_rs2_i));

  assert_wb_src_a_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o == 2'b01) |-> (wb_we_i && wb_rd_i == ex_rs1_i));

  assert_zero_reg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs1_i == '0) |-> fwd_a_o == 2'b00);

  assert_no_code3_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o != 2'b11) && (fwd_b_o != 2'b11));

  assert_stall_bubble_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (bubble_o && ex_is_load_i && (|ex_rd_i)));

  assert_single_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);

  assert_branch_kill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_taken_i |-> (flush_o && bubble_o && !stall_o));
endmodule

bind fwd_hazard_unit fwd_hazard_checker #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_fwd_hazard_unit.sv
module tb_fwd_hazard_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  typedef struct packed {
    logic [4:0] rs1, rs2, mrd;
    logic       mwe;
    logic [4:0] wrd;
    logic       wwe;
    logic [1:0] ea, eb;
    logic [3:0] req;
  } vec_t;

  // rs1 rs2 mem_rd mem_we wb_rd wb_we exp_a exp_b req
  localparam vec_t VECS [NV] = '{
    '{5'd3,  5'd4,  5'd3,  1'b1, 5'd9,  1'b1, 2'b10, 2'b00, 4'd1}, // R1
    '{5'd5,  5'd7,  5'd2,  1'b1, 5'd7,  1'b1, 2'b00, 2'b01, 4'd2}, // R2
    '{5'd6,  5'd6,  5'd6,  1'b1, 5'd6,  1'b1, 2'b10, 2'b10, 4'd3}, // R3
    '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00, 4'd4}, // R4
    '{5'd8,  5'd9,  5'd8,  1'b0, 5'd9,  1'b0, 2'b00, 2'b00, 4'd4}, // R4
    '{5'd10, 5'd11, 5'd12, 1'b1, 5'd13, 1'b1, 2'b00, 2'b00, 4'd5}, // R5
    '{5'd14, 5'd14, 5'd1,  1'b0, 5'd14, 1'b1, 2'b01, 2'b01, 4'd2}, // R2
    '{5'd31, 5'd2,  5'd31, 1'b1, 5'd2,  1'b1, 2'b10, 2'b01, 4'd1}, // R1
    '{5'd4,  5'd4,  5'd4,  1'b0, 5'd4,  1'b1, 2'b01, 2'b01, 4'd3}  // R3
  };

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [4:0] id_rs1_i = '0, id_rs2_i = '0, ex_rs1_i = '0, ex_rs2_i = '0;
  logic [4:0] ex_rd_i = '0, mem_rd_i = '0, wb_rd_i = '0;
  logic       ex_is_load_i = 1'b0, mem_we_i = 1'b0, wb_we_i = 1'b0;
  logic       branch_taken_i = 1'b0;
  logic [1:0] fwd_a_o, fwd_b_o;
  logic       stall_o, bubble_o, flush_o;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fwd_hazard_unit dut (.*);

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_lu(input logic ld, input logic [4:0] rd,
                        input logic [4:0] r1, input logic [4:0] r2, input logic br);
    @(negedge clk_i);
    ex_is_load_i = ld; ex_rd_i = rd; id_rs1_i = r1; id_rs2_i = r2; branch_taken_i = br;
    #1;
  endtask

  // {stall, bubble, flush}
  function automatic logic [3:0] ctl();
    return {1'b0, stall_o, bubble_o, flush_o};
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    #1;
    chk("R5 reset fwd_a", {2'b00, fwd_a_o}, 4'h0);
    chk("R5 reset ctl", ctl(), 4'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      ex_rs1_i = VECS[i].rs1; ex_rs2_i = VECS[i].rs2;
      mem_rd_i = VECS[i].mrd; mem_we_i = VECS[i].mwe;
      wb_rd_i  = VECS[i].wrd; wb_we_i  = VECS[i].wwe;
      #1;
      chk($sformatf("R%0d vec%0d fwd_a", VECS[i].req, i), {2'b00, fwd_a_o}, {2'b00, VECS[i].ea});
      chk($sformatf("R%0d vec%0d fwd_b", VECS[i].req, i), {2'b00, fwd_b_o}, {2'b00, VECS[i].eb});
    end

    // R7: not a load, then load with no match
    set_lu(1'b0, 5'd7, 5'd7, 5'd7, 1'b0);
    chk("R7 non-load", ctl(), 4'h0);
    set_lu(1'b1, 5'd7, 5'd8, 5'd9, 1'b0);
    chk("R7 no match", ctl(), 4'h0);
    // R4: load to register 0
    set_lu(1'b1, 5'd0, 5'd0, 5'd0, 1'b0);
    chk("R4 x0 load", ctl(), 4'h0);
    // R6 on rs2, then R8 held
    set_lu(1'b1, 5'd9, 5'd1, 5'd9, 1'b0);
    chk("R6 rs2 stall", ctl(), 4'h6);
    @(negedge clk_i); #1;
    chk("R8 held no restall", ctl(), 4'h0);
    set_lu(1'b0, 5'd0, 5'd0, 5'd0, 1'b0);
    set_lu(1'b1, 5'd12, 5'd12, 5'd3, 1'b0);
    chk("R6 rs1 stall", ctl(), 4'h6);
    // R9 taken branch with load-use present
    set_lu(1'b1, 5'd12, 5'd12, 5'd3, 1'b1);
    chk("R9 branch flush", ctl(), 4'h3);
    set_lu(1'b0, 5'd0, 5'd0, 5'd0, 1'b1);
    chk("R9 branch plain", ctl(), 4'h3);
    // R10: stall, reset mid-window, stall again at once
    set_lu(1'b1, 5'd5, 5'd5, 5'd5, 1'b0);
    chk("R10 pre", ctl(), 4'h6);
    @(posedge clk_i); #1;
    rst_ni = 1'b0; #1; rst_ni = 1'b1; #1;
    chk("R10 after reset", ctl(), 4'h6);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule